// File: doc/BRIEF.md
# Circular Operand Queue Address Calculator

This block locates operands for a processor that keeps intermediate values in a circular queue of registers instead of named registers. Each decoded instruction carries two sign-and-magnitude offsets. Sources are found relative to the queue head. The result slot is always the current tail. The block drives the source and destination slot indices in the same cycle, and it checks that every source lies inside the live part of the queue and that a new result would not overrun the oldest live entry. It then moves the head, tail and live-head pointers together on the next clock edge.

A small queue register file with two read ports and one write port is part of the block. The read ports are addressed by the two computed source slots. The write port is driven from outside, for example by a result bus, and writes may arrive in any order. An issue stage presents one instruction per cycle with `issue_valid`. It reads `accept` to learn whether the instruction took effect. When `dst_valid` is high it records `dst_slot` as the place where that instruction's result must later be written.

Top module: `queue_addr_calc`

## Requirements
- R1: While `rst` is high at a clock edge, the head, tail and live-head pointers become 0 and every queue word becomes 0.
- R2: An instruction is 16 bits. Bits 15:8 are the opcode. Its bits 15:12 select the kind: 1 = load, 2 = two-operand, 3 = one-operand, 4 = store, 5 = duplicate, 6 = release, and any other value = no operation. Bits 11:8 are ignored. Bit 7 is the sign and bits 6:4 the magnitude of offset A. Bit 3 is the sign and bits 2:0 the magnitude of offset B.
- R3: `src_a_slot` = head + A, and `src_b_slot` = head + 1 when B's magnitude is zero, otherwise head + B. A negative sign subtracts the magnitude, a zero magnitude counts as zero whatever its sign, and all sums wrap modulo the depth.
- R4: An accepted load, two-operand, one-operand or duplicate instruction raises `dst_valid`, and its destination is the current tail. The tail then advances by one. No other kind moves the tail.
- R5: On acceptance the head advances by the number of used operands whose offset magnitude is zero. Two-operand instructions use A and B; one-operand and store instructions use A; duplicate uses A but never advances the head.
- R6: An accepted release instruction sets the live head to the current head.
- R7: A producing instruction raises `fault_full` when tail + 1 equals the live head. It is then not accepted and no pointer changes.
- R8: A used source slot whose distance past the live head (modulo depth) is not smaller than the live count (tail − live head) raises `fault_range`. The instruction is then not accepted and no pointer changes.
- R9: A write-port write lands on the clock edge, and each read port returns the stored word at its source slot.
- R10: With `issue_valid` low, the faults, `accept` and `dst_valid` stay low and no pointer moves. No-operation kinds are accepted and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| instr | input | 16 | Decoded instruction word |
| wr_en | input | 1 | Queue write enable |
| wr_slot | input | 4 | Queue write slot |
| wr_data | input | 16 | Queue write data |
| accept | output | 1 | Instruction takes effect at the next edge |
| fault_full | output | 1 | Result would overrun the live head |
| fault_range | output | 1 | A source lies outside the live window |
| src_a_slot | output | 4 | First source slot |
| src_b_slot | output | 4 | Second source slot |
| dst_slot | output | 4 | Destination slot (current tail) |
| dst_valid | output | 1 | Accepted instruction produces a result |
| rd_data_a | output | 16 | Queue word at the first source slot |
| rd_data_b | output | 16 | Queue word at the second source slot |
| qh | output | 4 | Queue head pointer |
| qt | output | 4 | Queue tail pointer |
| lqh | output | 4 | Live head pointer |

## Verification
The main sequence is a two-expression program: four loads, then an add that consumes both operands, then two-operand steps with offsets −2 and −1 that reach behind the head. This separates head-relative addressing from plain FIFO order and shows that a negative offset is not counted as consumed. Positive offsets, negative zero, a duplicate and one-operand reads on either side of the live head tell the window check apart from the address sum. A long run of loads wraps the tail through the top of the queue into the full condition, and idle cycles, ignored opcode bits and unknown kinds show that these inputs leave the pointers unchanged.

// File: rtl/qac_pkg.sv
package qac_pkg;

    localparam int OPW     = 8;
    localparam int OFFW    = 3;
    localparam int INSTR_W = OPW + 2 * (OFFW + 1);

    typedef enum logic [2:0] {
        K_NOP,
        K_LOAD,
        K_BIN,
        K_UNARY,
        K_STORE,
        K_DUP,
        K_RELEASE
    } kind_e;

    typedef struct packed {
        logic            neg;
        logic [OFFW-1:0] mag;
    } soff_t;

    typedef struct packed {
        soff_t off_a;
        soff_t off_b;
        logic  use_a;
        logic  use_b;
        logic  eat_a;
        logic  eat_b;
        logic  produce;
        logic  release_lqh;
    } dec_t;

    function automatic kind_e kind_of(input logic [3:0] grp);
        case (grp)
            4'h1:    return K_LOAD;
            4'h2:    return K_BIN;
            4'h3:    return K_UNARY;
            4'h4:    return K_STORE;
            4'h5:    return K_DUP;
            4'h6:    return K_RELEASE;
            default: return K_NOP;
        endcase
    endfunction

endpackage

// File: rtl/qac_decode.sv
module qac_decode
    import qac_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    kind_e kind;
    logic  unused_opcode_bits;

    assign kind               = kind_of(instr[INSTR_W-1 -: 4]);
    assign unused_opcode_bits = ^instr[INSTR_W-5 -: (OPW-4)];

    always_comb begin
        dec             = '0;
        dec.off_a       = soff_t'(instr[2*(OFFW+1)-1 -: (OFFW+1)]);
        dec.off_b       = soff_t'(instr[OFFW:0]);
        dec.use_a       = (kind == K_BIN) || (kind == K_UNARY) ||
                          (kind == K_STORE) || (kind == K_DUP);
        dec.use_b       = (kind == K_BIN);
        dec.eat_a       = dec.use_a && (kind != K_DUP) && (dec.off_a.mag == '0);
        dec.eat_b       = dec.use_b && (dec.off_b.mag == '0);
        dec.produce     = (kind == K_LOAD) || (kind == K_BIN) ||
                          (kind == K_UNARY) || (kind == K_DUP);
        dec.release_lqh = (kind == K_RELEASE);
    end

endmodule

// File: rtl/qac_addr.sv
module qac_addr
    import qac_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic [AW-1:0] qh,
    input  logic [AW-1:0] qt,
    input  logic [AW-1:0] lqh,
    input  dec_t          dec,
    output logic [AW-1:0] src_a,
    output logic [AW-1:0] src_b,
    output logic          full_hit,
    output logic          range_hit,
    output logic [AW-1:0] qh_nx,
    output logic [AW-1:0] qt_nx,
    output logic [AW-1:0] lqh_nx
);

    function automatic logic [AW-1:0] shift(input logic [AW-1:0] base, input soff_t so);
        logic [AW-1:0] m;
        m = AW'(so.mag);
        return so.neg ? (base - m) : (base + m);
    endfunction

    logic [AW-1:0] live;
    logic [AW-1:0] dist_a;
    logic [AW-1:0] dist_b;
    logic [AW-1:0] step;

    always_comb begin
        src_a = shift(qh, dec.off_a);
        src_b = (dec.off_b.mag == '0) ? (qh + AW'(1)) : shift(qh, dec.off_b);

        live   = qt - lqh;
        dist_a = src_a - lqh;
        dist_b = src_b - lqh;

        range_hit = (dec.use_a && !(dist_a < live)) ||
                    (dec.use_b && !(dist_b < live));
        full_hit  = dec.produce && ((qt + AW'(1)) == lqh);

        step   = AW'(dec.eat_a) + AW'(dec.eat_b);
        qh_nx  = qh + step;
        qt_nx  = qt + AW'(dec.produce);
        lqh_nx = dec.release_lqh ? qh : lqh;
    end

endmodule

// File: rtl/qac_qregs.sv
module qac_qregs #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/queue_addr_calc.sv
module queue_addr_calc
    import qac_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_slot,
    input  logic [WIDTH-1:0]   wr_data,
    output logic               accept,
    output logic               fault_full,
    output logic               fault_range,
    output logic [AW-1:0]      src_a_slot,
    output logic [AW-1:0]      src_b_slot,
    output logic [AW-1:0]      dst_slot,
    output logic               dst_valid,
    output logic [WIDTH-1:0]   rd_data_a,
    output logic [WIDTH-1:0]   rd_data_b,
    output logic [AW-1:0]      qh,
    output logic [AW-1:0]      qt,
    output logic [AW-1:0]      lqh
);

    dec_t          dec;
    logic          full_hit;
    logic          range_hit;
    logic [AW-1:0] qh_nx;
    logic [AW-1:0] qt_nx;
    logic [AW-1:0] lqh_nx;

    qac_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    qac_addr #(.AW(AW)) u_addr (
        .qh        (qh),
        .qt        (qt),
        .lqh       (lqh),
        .dec       (dec),
        .src_a     (src_a_slot),
        .src_b     (src_b_slot),
        .full_hit  (full_hit),
        .range_hit (range_hit),
        .qh_nx     (qh_nx),
        .qt_nx     (qt_nx),
        .lqh_nx    (lqh_nx)
    );

    qac_qregs #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (wr_slot),
        .wdata   (wr_data),
        .raddr_a (src_a_slot),
        .raddr_b (src_b_slot),
        .rdata_a (rd_data_a),
        .rdata_b (rd_data_b)
    );

    assign fault_full  = issue_valid && full_hit;
    assign fault_range = issue_valid && range_hit;
    assign accept      = issue_valid && !full_hit && !range_hit;
    assign dst_valid   = accept && dec.produce;
    assign dst_slot    = qt;

    always_ff @(posedge clk) begin
        if (rst) begin
            qh  <= '0;
            qt  <= '0;
            lqh <= '0;
        end else if (accept) begin
            qh  <= qh_nx;
            qt  <= qt_nx;
            lqh <= lqh_nx;
        end
    end

endmodule

// File: rtl/queue_addr_calc_chk.sv
module queue_addr_calc_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          issue_valid,
    input logic [3:0]    op_grp,
    input logic          accept,
    input logic          fault_full,
    input logic          fault_range,
    input logic          dst_valid,
    input logic [AW-1:0] qh,
    input logic [AW-1:0] qt,
    input logic [AW-1:0] lqh
);

    a_r7_full_freezes: assert property (@(posedge clk) disable iff (rst)
        fault_full |=> ($stable(qh) && $stable(qt) && $stable(lqh)));

    a_r8_range_freezes: assert property (@(posedge clk) disable iff (rst)
        fault_range |=> ($stable(qh) && $stable(qt) && $stable(lqh)));

    a_r10_idle_freezes: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> ($stable(qh) && $stable(qt) && $stable(lqh)));

    a_r4_tail_steps_one: assert property (@(posedge clk) disable iff (rst)
        dst_valid |=> (AW'(qt - $past(qt)) == AW'(1)));

    a_r7_tail_never_meets_live_head: assert property (@(posedge clk) disable iff (rst)
        dst_valid |=> (qt != lqh));

    a_r6_release_copies_head: assert property (@(posedge clk) disable iff (rst)
        (accept && op_grp == 4'h6) |=> (lqh == $past(qh)));

    a_r5_head_step_bounded: assert property (@(posedge clk) disable iff (rst)
        accept |=> (AW'(qh - $past(qh)) <= AW'(2)));

endmodule

bind queue_addr_calc queue_addr_calc_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .op_grp      (instr[15:12]),
    .accept      (accept),
    .fault_full  (fault_full),
    .fault_range (fault_range),
    .dst_valid   (dst_valid),
    .qh          (qh),
    .qt          (qt),
    .lqh         (lqh)
);

// File: tb/queue_addr_calc_test.sv
module queue_addr_calc_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic [15:0] instr;
    logic        wr_en;
    logic [3:0]  wr_slot;
    logic [15:0] wr_data;
    logic        accept, fault_full, fault_range, dst_valid;
    logic [3:0]  src_a_slot, src_b_slot, dst_slot, qh, qt, lqh;
    logic [15:0] rd_data_a, rd_data_b;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    queue_addr_calc uut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
        .accept(accept), .fault_full(fault_full), .fault_range(fault_range),
        .src_a_slot(src_a_slot), .src_b_slot(src_b_slot), .dst_slot(dst_slot),
        .dst_valid(dst_valid), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .qh(qh), .qt(qt), .lqh(lqh)
    );

    typedef struct packed {
        logic [15:0] ins;
        logic        acc;
        logic        ff;
        logic        fr;
        logic [3:0]  sa;
        logic [3:0]  sb;
        logic        dv;
        logic [3:0]  dst;
        logic [3:0]  nqh;
        logic [3:0]  nqt;
        logic [3:0]  nlqh;
    } vec_t;

    // Two-expression program, then release, empty-queue fault and no-op kinds.
    localparam vec_t VEC [14] = '{
        '{16'h1000, 1'b1, 1'b0, 1'b0, 4'd0, 4'd1, 1'b1, 4'd0,  4'd0, 4'd1, 4'd0},
        '{16'h1000, 1'b1, 1'b0, 1'b0, 4'd0, 4'd1, 1'b1, 4'd1,  4'd0, 4'd2, 4'd0},
        '{16'h1000, 1'b1, 1'b0, 1'b0, 4'd0, 4'd1, 1'b1, 4'd2,  4'd0, 4'd3, 4'd0},
        '{16'h1000, 1'b1, 1'b0, 1'b0, 4'd0, 4'd1, 1'b1, 4'd3,  4'd0, 4'd4, 4'd0},
        '{16'h2000, 1'b1, 1'b0, 1'b0, 4'd0, 4'd1, 1'b1, 4'd4,  4'd2, 4'd5, 4'd0},
        '{16'h2300, 1'b1, 1'b0, 1'b0, 4'd2, 4'd3, 1'b1, 4'd5,  4'd4, 4'd6, 4'd0},
        '{16'h200A, 1'b1, 1'b0, 1'b0, 4'd4, 4'd2, 1'b1, 4'd6,  4'd5, 4'd7, 4'd0},
        '{16'h2009, 1'b1, 1'b0, 1'b0, 4'd5, 4'd4, 1'b1, 4'd7,  4'd6, 4'd8, 4'd0},
        '{16'h4000, 1'b1, 1'b0, 1'b0, 4'd6, 4'd7, 1'b0, 4'd8,  4'd7, 4'd8, 4'd0},
        '{16'h4000, 1'b1, 1'b0, 1'b0, 4'd7, 4'd8, 1'b0, 4'd8,  4'd8, 4'd8, 4'd0},
        '{16'h6000, 1'b1, 1'b0, 1'b0, 4'd8, 4'd9, 1'b0, 4'd8,  4'd8, 4'd8, 4'd8},
        '{16'h2000, 1'b0, 1'b0, 1'b1, 4'd8, 4'd9, 1'b0, 4'd8,  4'd8, 4'd8, 4'd8},
        '{16'h0000, 1'b1, 1'b0, 1'b0, 4'd8, 4'd9, 1'b0, 4'd8,  4'd8, 4'd8, 4'd8},
        '{16'hF000, 1'b1, 1'b0, 1'b0, 4'd8, 4'd9, 1'b0, 4'd8,  4'd8, 4'd8, 4'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] w);
        @(negedge clk);
        issue_valid = 1'b1;
        instr = w;
        #1;
    endtask

    task automatic commit();
        @(posedge clk);
        #1;
        issue_valid = 1'b0;
    endtask

    task automatic ptrs(input string req, input logic [3:0] eh, input logic [3:0] et, input logic [3:0] el);
        check({req, " qh"}, 32'(qh), 32'(eh));
        check({req, " qt"}, 32'(qt), 32'(et));
        check({req, " lqh"}, 32'(lqh), 32'(el));
    endtask

    task automatic write_q(input logic [3:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_slot = s; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; issue_valid = 1'b0; instr = 16'h0;
        wr_en = 1'b0; wr_slot = 4'h0; wr_data = 16'h0;
        repeat (2) @(posedge clk);
        #1;
        ptrs("R1 reset", 4'd0, 4'd0, 4'd0);
        @(negedge clk);
        rst = 1'b0;

        // R3 R4 R5 R6 R8 R10 vector walk
        for (int i = 0; i < 14; i++) begin
            drive(VEC[i].ins);
            check($sformatf("R2/R10 accept v%0d", i), 32'(accept), 32'(VEC[i].acc));
            check($sformatf("R7 fault_full v%0d", i), 32'(fault_full), 32'(VEC[i].ff));
            check($sformatf("R8 fault_range v%0d", i), 32'(fault_range), 32'(VEC[i].fr));
            check($sformatf("R3 src_a v%0d", i), 32'(src_a_slot), 32'(VEC[i].sa));
            check($sformatf("R3 src_b v%0d", i), 32'(src_b_slot), 32'(VEC[i].sb));
            check($sformatf("R4 dst_valid v%0d", i), 32'(dst_valid), 32'(VEC[i].dv));
            check($sformatf("R4 dst_slot v%0d", i), 32'(dst_slot), 32'(VEC[i].dst));
            commit();
            ptrs($sformatf("R5/R6 v%0d", i), VEC[i].nqh, VEC[i].nqt, VEC[i].nlqh);
        end

        // R9 data path: two loads, then fill their slots
        drive(16'h1000); check("R4 load dst", 32'(dst_slot), 32'd8); commit();
        drive(16'h1000); check("R4 load dst", 32'(dst_slot), 32'd9); commit();
        write_q(4'd8, 16'h1111);
        write_q(4'd9, 16'h2222);
        ptrs("R10 write keeps pointers", 4'd8, 4'd10, 4'd8);

        // R5 duplicate with +1 reads head+1, head stays
        drive(16'h5010);
        check("R3 dup src_a", 32'(src_a_slot), 32'd9);
        check("R9 dup read", 32'(rd_data_a), 32'h2222);
        check("R4 dup dst", 32'(dst_slot), 32'd10);
        check("R4 dup dst_valid", 32'(dst_valid), 32'd1);
        commit();
        ptrs("R5 dup no consume", 4'd8, 4'd11, 4'd8);

        // one-operand at head consumes one
        drive(16'h3000);
        check("R9 unary read", 32'(rd_data_a), 32'h1111);
        check("R9 unary read b", 32'(rd_data_b), 32'h2222);
        commit();
        ptrs("R5 unary consume", 4'd9, 4'd12, 4'd8);

        // -2 reaches behind live head: range fault
        drive(16'h30A0);
        check("R3 src_a -2", 32'(src_a_slot), 32'd7);
        check("R8 behind live head", 32'(fault_range), 32'd1);
        check("R8 not accepted", 32'(accept), 32'd0);
        commit();
        ptrs("R8 frozen", 4'd9, 4'd12, 4'd8);

        // -1 lands on live head: allowed, not consumed
        drive(16'h3090);
        check("R8 at live head ok", 32'(accept), 32'd1);
        check("R9 read behind head", 32'(rd_data_a), 32'h1111);
        commit();
        ptrs("R5 negative not consumed", 4'd9, 4'd13, 4'd8);

        // +4 on B reaches the tail slot: range fault
        drive(16'h2004);
        check("R3 src_b +4", 32'(src_b_slot), 32'd13);
        check("R8 at tail", 32'(fault_range), 32'd1);
        commit();
        ptrs("R8 frozen tail", 4'd9, 4'd13, 4'd8);

        // negative zero on B behaves as zero
        drive(16'h2008);
        check("R3 neg zero src_b", 32'(src_b_slot), 32'd10);
        check("R3 neg zero accept", 32'(accept), 32'd1);
        commit();
        ptrs("R5 neg zero consumes two", 4'd11, 4'd14, 4'd8);

        // R7 fill with wrap 14,15,0..6
        for (int k = 0; k < 9; k++) begin
            drive(16'h1000);
            check("R4 wrap dst", 32'(dst_slot), 32'((14 + k) % 16));
            check("R7 not yet full", 32'(fault_full), 32'd0);
            commit();
        end
        ptrs("R4 wrapped tail", 4'd11, 4'd7, 4'd8);
        drive(16'h1000);
        check("R7 full fault", 32'(fault_full), 32'd1);
        check("R7 full not accepted", 32'(accept), 32'd0);
        check("R7 full no dst", 32'(dst_valid), 32'd0);
        commit();
        ptrs("R7 frozen", 4'd11, 4'd7, 4'd8);

        // R10 idle with a faulting word on the bus
        @(negedge clk);
        issue_valid = 1'b0; instr = 16'h1000;
        #1;
        check("R10 idle accept", 32'(accept), 32'd0);
        check("R10 idle fault", 32'(fault_full), 32'd0);
        check("R10 idle dst_valid", 32'(dst_valid), 32'd0);
        @(posedge clk); #1;
        ptrs("R10 idle", 4'd11, 4'd7, 4'd8);

        // R1 storage clear: slot 11 (head) holds data, then reset
        write_q(4'd11, 16'hBEEF);
        @(negedge clk); instr = 16'h3000; #1;
        check("R9 head read", 32'(rd_data_a), 32'hBEEF);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        ptrs("R1 mid reset", 4'd0, 4'd0, 4'd0);
        @(negedge clk); rst = 1'b0; instr = 16'h30B0; #1;
        check("R1 cleared word", 32'(src_a_slot), 32'd13);
        check("R1 cleared data", 32'(rd_data_a), 32'd0);
        check("R1 cleared data b", 32'(rd_data_b), 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule